// File: doc/BRIEF.md
# Interrupt-Capable Sixteen-Pin I/O Bank

This block is a bank of sixteen general-purpose pins. Each pin has one bit in every register, and software reaches the registers through a flat 16-bit register port: address, write strobe, write data, and read data that follows the address without delay. Software sets which pins drive and what value they drive. It can select the alternate function of a pin and read back the synchronized level of every pin.

Each pin also acts as an interrupt source. A per-pin type bit chooses between edge detection and level detection, and each type has its own polarity register. Detected events are held in a pending register. They stay there until software writes zeros over them, and an event that arrives in the same cycle as that write is kept. One bank interrupt line goes to an upstream aggregator and is gated by the interrupt mask. A wake request is gated by a separate sleep mask.

Top module: `gpio_irq_bank`

## Requirements
- R1: On reset, the interrupt mask (address 4) and the sleep mask (address 9) read all ones. Every other register reads zero, and `bank_irq`, `wake_req`, `pin_oe` and `pin_out` are low.
- R2: The register map is: 0 direction, 1 output value, 3 alternate select. Each of these is a read/write register. `pin_oe` follows direction, with 1 meaning output. `pin_out` follows the output value register and `alt_sel` follows the alternate select register, each one cycle after the write.
- R3: Address 2 returns the pin levels through a two-stage synchronizer. A level presented on `pin_in` before a rising edge is visible in a read after the second rising edge.
- R4: When a pin's type bit (address 5) is 1, the pin is edge triggered. A polarity bit (address 6) of 1 catches rising edges of the synchronized level and 0 catches falling edges. The pending bit sets one cycle after the new level is readable at address 2.
- R5: When a pin's type bit is 0, the pin is level triggered. Its pending bit is set on every cycle that the synchronized level equals the level polarity bit (address 7).
- R6: A write to the pending register (address 8) clears the bits written as 0 and keeps the bits written as 1. An event detected in the cycle of that write still leaves its bit set.
- R7: `bank_irq` is high exactly when some pending bit has a mask bit (address 4) of 0. Pending bits latch whether or not the pin is masked.
- R8: `wake_req` is high exactly when some pending bit has a sleep-mask bit (address 9) of 0.
- R9: Writes to address 2 and to unused addresses 10 to 15 change no state. Unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address, shared by reads and writes |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| pin_in | input | 16 | Raw pin levels, asynchronous |
| pin_out | output | 16 | Output drive values |
| pin_oe | output | 16 | Output enables |
| alt_sel | output | 16 | Alternate function select per pin |
| bank_irq | output | 1 | Bank interrupt to the aggregator |
| wake_req | output | 1 | Wake-up request |

## Verification
If the synchronizer or the previous-level register is wrong, the result is a pending bit that sets one cycle early or late, or an edge of the wrong direction being caught. This shows in the next read of address 8 and on `bank_irq` in the cycle after the level changes at address 2. If the clear logic is wrong, a pending bit can be lost when its event coincides with the clearing write, or a bit written as 1 can be dropped; either error is visible in the first read after that write. A wrong mask or sleep-mask path shows on `bank_irq` or `wake_req` in the same cycle that the register is read back.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    A_DIR   = 4'd0,
    A_OUT   = 4'd1,
    A_PIN   = 4'd2,
    A_ALT   = 4'd3,
    A_MASK  = 4'd4,
    A_TRIG  = 4'd5,
    A_EPOL  = 4'd6,
    A_LPOL  = 4'd7,
    A_STAT  = 4'd8,
    A_SLEEP = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W           = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stg_q [SYNC_STAGES];
  logic [W-1:0] prev_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = din;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg_q[SYNC_STAGES-1];
  end

  assign cur_o  = stg_q[SYNC_STAGES-1];
  assign prev_o = prev_q;

  // Warm-up counter: enables the latency check only once enough edges have passed since reset.
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  if (SYNC_STAGES == 2) begin : g_chk
    // R3
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q >= 2'd2) |-> (cur_o == $past(din, 2)));
  end
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] trig,
  input  logic [W-1:0] epol,
  input  logic [W-1:0] lpol,
  output logic [W-1:0] evt
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    logic rose, fell, edge_hit, lvl_hit;
    assign rose     = cur[p] & ~prev[p];
    assign fell     = ~cur[p] & prev[p];
    assign edge_hit = epol[p] ? rose : fell;
    assign lvl_hit  = ~(cur[p] ^ lpol[p]);
    assign evt[p]   = trig[p] ? edge_hit : lvl_hit;
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] sleep,
  output logic [W-1:0] stat_o,
  output logic         irq_o,
  output logic         wake_o
);
  logic [W-1:0] stat_q, stat_d;
  logic         stat_en;

  always_comb begin
    stat_en = clr_we | (|evt);
    stat_d  = (clr_we ? (stat_q & clr_data) : stat_q) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & ~mask);
  assign wake_o = |(stat_q & ~sleep);

  // R6
  evt_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));
  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_data == '0 && evt == '0) |=> (stat_q == '0));
  // R4
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == '0 && !clr_we) |=> $stable(stat_q));
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      alt_o,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      trig_o,
  output logic [W-1:0]      epol_o,
  output logic [W-1:0]      lpol_o,
  output logic [W-1:0]      sleep_o
);
  logic [W-1:0] dir_q, out_q, alt_q, mask_q, trig_q, epol_q, lpol_q, sleep_q;
  logic wr_dir, wr_out, wr_alt, wr_mask, wr_trig, wr_epol, wr_lpol, wr_sleep;

  always_comb begin
    wr_dir   = we && (addr == A_DIR);
    wr_out   = we && (addr == A_OUT);
    wr_alt   = we && (addr == A_ALT);
    wr_mask  = we && (addr == A_MASK);
    wr_trig  = we && (addr == A_TRIG);
    wr_epol  = we && (addr == A_EPOL);
    wr_lpol  = we && (addr == A_LPOL);
    wr_sleep = we && (addr == A_SLEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      alt_q   <= '0;
      mask_q  <= '1;
      trig_q  <= '0;
      epol_q  <= '0;
      lpol_q  <= '0;
      sleep_q <= '1;
    end else begin
      if (wr_dir)   dir_q   <= wdata;
      if (wr_out)   out_q   <= wdata;
      if (wr_alt)   alt_q   <= wdata;
      if (wr_mask)  mask_q  <= wdata;
      if (wr_trig)  trig_q  <= wdata;
      if (wr_epol)  epol_q  <= wdata;
      if (wr_lpol)  lpol_q  <= wdata;
      if (wr_sleep) sleep_q <= wdata;
    end
  end

  assign dir_o   = dir_q;
  assign out_o   = out_q;
  assign alt_o   = alt_q;
  assign mask_o  = mask_q;
  assign trig_o  = trig_q;
  assign epol_o  = epol_q;
  assign lpol_o  = lpol_q;
  assign sleep_o = sleep_q;

  // R9
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (addr == A_PIN || addr > A_SLEEP)) |=>
      ($stable(dir_q) && $stable(out_q) && $stable(alt_q) && $stable(mask_q) &&
       $stable(trig_q) && $stable(epol_q) && $stable(lpol_q) && $stable(sleep_q)));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  alt_sel,
  output logic              bank_irq,
  output logic              wake_req
);
  localparam int unsigned W = NPINS;

  logic [W-1:0] dir_w, out_w, alt_w, mask_w, trig_w, epol_w, lpol_w, sleep_w;
  logic [W-1:0] cur_w, prev_w, evt_w, stat_w;
  logic         stat_clr;

  gpio_cfg_regs #(.W(W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .dir_o(dir_w), .out_o(out_w), .alt_o(alt_w), .mask_o(mask_w),
    .trig_o(trig_w), .epol_o(epol_w), .lpol_o(lpol_w), .sleep_o(sleep_w)
  );

  gpio_in_sync #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .cur_o(cur_w), .prev_o(prev_w)
  );

  gpio_evt_detect #(.W(W)) u_det (
    .cur(cur_w), .prev(prev_w), .trig(trig_w), .epol(epol_w), .lpol(lpol_w),
    .evt(evt_w)
  );

  assign stat_clr = reg_we && (reg_addr == A_STAT);

  gpio_irq_status #(.W(W)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt(evt_w), .clr_we(stat_clr), .clr_data(reg_wdata),
    .mask(mask_w), .sleep(sleep_w), .stat_o(stat_w), .irq_o(bank_irq), .wake_o(wake_req)
  );

  always_comb begin
    case (reg_addr)
      A_DIR:   reg_rdata = dir_w;
      A_OUT:   reg_rdata = out_w;
      A_PIN:   reg_rdata = cur_w;
      A_ALT:   reg_rdata = alt_w;
      A_MASK:  reg_rdata = mask_w;
      A_TRIG:  reg_rdata = trig_w;
      A_EPOL:  reg_rdata = epol_w;
      A_LPOL:  reg_rdata = lpol_w;
      A_STAT:  reg_rdata = stat_w;
      A_SLEEP: reg_rdata = sleep_w;
      default: reg_rdata = '0;
    endcase
  end

  assign pin_out = out_w;
  assign pin_oe  = dir_w;
  assign alt_sel = alt_w;

  // R7
  full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_w == '1) |-> !bank_irq);
  // R8
  full_sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_w == '1) |-> !wake_req);
  // R4
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_w & trig_w & epol_w & ~(cur_w & ~$past(cur_w))) == '0));
  // R4
  fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_w & trig_w & ~epol_w & ~(~cur_w & $past(cur_w))) == '0));
endmodule

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
  localparam int CLK_P = 10;
  localparam int W     = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   reg_addr;
  logic         reg_we;
  logic [W-1:0] reg_wdata, reg_rdata, pin_in, pin_out, pin_oe, alt_sel;
  logic         bank_irq, wake_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_irq_bank dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel),
    .bank_irq(bank_irq), .wake_req(wake_req)
  );

  // Reference state built from the requirements
  logic [W-1:0] m_dir, m_out, m_alt, m_mask, m_trig, m_epol, m_lpol, m_sleep;
  logic [W-1:0] m_s1, m_s2, m_prev, m_stat;

  function automatic logic [W-1:0] evt_of(logic [W-1:0] c, logic [W-1:0] p,
                                          logic [W-1:0] t, logic [W-1:0] e,
                                          logic [W-1:0] l);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++)
      r[i] = t[i] ? (e[i] ? (c[i] & ~p[i]) : (~c[i] & p[i])) : (c[i] == l[i]);
    return r;
  endfunction

  function automatic logic [W-1:0] model_read(logic [3:0] a);
    case (a)
      4'd0: return m_dir;
      4'd1: return m_out;
      4'd2: return m_s2;
      4'd3: return m_alt;
      4'd4: return m_mask;
      4'd5: return m_trig;
      4'd6: return m_epol;
      4'd7: return m_lpol;
      4'd8: return m_stat;
      4'd9: return m_sleep;
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] a);
    case (a)
      4'd0, 4'd1, 4'd3: return "R2";
      4'd2: return "R3";
      4'd4: return "R7";
      4'd5, 4'd6: return "R4";
      4'd7: return "R5";
      4'd8: return "R6";
      4'd9: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '0; m_out = '0; m_alt = '0; m_mask = '1; m_trig = '0;
      m_epol = '0; m_lpol = '0; m_sleep = '1;
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_stat = '0;
    end else begin
      logic [W-1:0] ev, ns;
      ev = evt_of(m_s2, m_prev, m_trig, m_epol, m_lpol);
      ns = ((reg_we && reg_addr == 4'd8) ? (m_stat & reg_wdata) : m_stat) | ev;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in; m_stat = ns;
      if (reg_we) begin
        case (reg_addr)
          4'd0: m_dir   = reg_wdata;
          4'd1: m_out   = reg_wdata;
          4'd3: m_alt   = reg_wdata;
          4'd4: m_mask  = reg_wdata;
          4'd5: m_trig  = reg_wdata;
          4'd6: m_epol  = reg_wdata;
          4'd7: m_lpol  = reg_wdata;
          4'd9: m_sleep = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic we, logic [3:0] a, logic [W-1:0] d, logic [W-1:0] p);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; pin_in = p;
    #1;
    chk(tag_of(a), reg_rdata, model_read(a));
    chk("R7", {15'd0, bank_irq}, {15'd0, |(m_stat & ~m_mask)});
    chk("R8", {15'd0, wake_req}, {15'd0, |(m_stat & ~m_sleep)});
    chk("R2", pin_out, m_out);
    chk("R2", pin_oe, m_dir);
    chk("R2", alt_sel, m_alt);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] pins;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 4'd4; reg_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", reg_rdata, 16'hffff);
    chk("R1", {15'd0, bank_irq}, 16'd0);
    chk("R1", {15'd0, wake_req}, 16'd0);
    chk("R1", pin_oe, 16'd0);
    chk("R1", pin_out, 16'd0);

    // R6: rising edge on pin 0 coinciding with a clearing write
    step(1, 4'd5, 16'hffff, 16'h0000);
    step(1, 4'd6, 16'hffff, 16'h0000);
    step(1, 4'd4, 16'h0000, 16'h0000);
    step(1, 4'd8, 16'h0000, 16'h0000);
    step(0, 4'd8, 16'h0000, 16'h0001); chk("R6", reg_rdata, 16'h0000);
    step(0, 4'd8, 16'h0000, 16'h0001);
    step(1, 4'd8, 16'h0000, 16'h0001); chk("R6", reg_rdata, 16'h0000);
    step(0, 4'd8, 16'h0000, 16'h0001); chk("R6", reg_rdata, 16'h0001);
    chk("R7", {15'd0, bank_irq}, 16'd1);

    // R7: masked pin stays pending but the line is low
    step(1, 4'd4, 16'hffff, 16'h0001);
    step(0, 4'd8, 16'h0000, 16'h0001);
    chk("R7", {15'd0, bank_irq}, 16'd0);
    chk("R7", reg_rdata, 16'h0001);
    chk("R8", {15'd0, wake_req}, 16'd0);
    step(1, 4'd9, 16'hfffe, 16'h0001);
    step(0, 4'd8, 16'h0000, 16'h0001);
    chk("R8", {15'd0, wake_req}, 16'd1);

    // R9: writes to the pin address and unused addresses do nothing
    step(1, 4'd2, 16'h0000, 16'h0001);
    step(1, 4'd12, 16'hffff, 16'h0001);
    step(0, 4'd2, 16'h0000, 16'h0001); chk("R9", reg_rdata, 16'h0001);
    step(0, 4'd0, 16'h0000, 16'h0001); chk("R9", reg_rdata, 16'h0000);
    step(0, 4'd12, 16'h0000, 16'h0001); chk("R9", reg_rdata, 16'h0000);

    // R5: level-high on pin 0 re-pends right after a clear
    step(1, 4'd7, 16'hffff, 16'h0001);
    step(1, 4'd5, 16'h0000, 16'h0001);
    step(1, 4'd8, 16'h0000, 16'h0001);
    step(0, 4'd8, 16'h0000, 16'h0001); chk("R5", reg_rdata, 16'h0001);

    // R4: falling edge on pin 0
    step(1, 4'd5, 16'hffff, 16'h0001);
    step(1, 4'd6, 16'hfffe, 16'h0001);
    step(1, 4'd8, 16'h0000, 16'h0001);
    step(0, 4'd8, 16'h0000, 16'h0000); chk("R6", reg_rdata, 16'h0000);
    step(0, 4'd8, 16'h0000, 16'h0000);
    step(0, 4'd8, 16'h0000, 16'h0000); chk("R4", reg_rdata, 16'h0000);
    step(0, 4'd8, 16'h0000, 16'h0000); chk("R4", reg_rdata, 16'h0001);

    // Constrained random mix of writes, reads and pin activity
    pins = 16'h0000;
    for (int i = 0; i < 4000; i++) begin
      logic we;
      logic [3:0] a;
      logic [W-1:0] d;
      if ($urandom % 4 == 0) pins = pins ^ W'($urandom);
      we = ($urandom % 3 == 0);
      a  = 4'($urandom % 12);
      d  = W'($urandom);
      if (we && a == 4'd8 && ($urandom % 2 == 0)) d = '0;
      step(we, a, d, pins);
    end

    finish_run();
  end
endmodule